// File: doc/BRIEF.md
# Tag-Decoded Shared Memory Controller

This block sits between a datapath and a set of on-chip block RAMs, one RAM per array. The datapath issues loads and stores on a single request port using 32-bit pointer-style addresses. The upper field of each address names an array by tag. The lower field is the element index, and it is passed unchanged as the address of the chosen RAM. The tag decides which RAM is enabled for the access. A registered copy of the decode then decides, one cycle later, which RAM's read data is returned.

Two tags are kept out of the array space. Tag zero marks a null pointer and always produces an error response. Tag one marks external memory and is forwarded on a separate request/response handshake, and the controller stalls until the external side answers. Each RAM is exactly as wide as its array's elements, and its read data is zero-extended onto the 32-bit response. An index past the end of the addressed array is rejected rather than wrapped. The same applies to a tag that no array owns.

Top module: `tagmem_ctrl`

## Requirements
- R1: Address bits 31:23 are the tag and bits 22:0 are the index. Tag 2+k selects array k, and the index addresses that array's RAM directly. With the default parameters, array 0 has 100 entries of 32 bits and array 1 has 64 entries of 16 bits.
- R2: A load accepted on a valid array tag and in-range index gives rsp_valid=1 in the next cycle, with rsp_err=0 and the stored element on rsp_rdata.
- R3: A store accepted on a valid array tag and in-range index writes the low element-width bits of req_wdata into that one entry only. It gives rsp_valid=1 in the next cycle with rsp_err=0 and rsp_rdata=0.
- R4: An element narrower than 32 bits is returned with its upper rsp_rdata bits at zero.
- R5: A request with tag 0 gives rsp_valid=1 and rsp_err=1 in the next cycle with rsp_rdata=0, and it writes nothing.
- R6: An index equal to or beyond the addressed array's depth is handled like R5. Its low bits must not alias onto any entry.
- R7: A tag of 2+NUM_ARR or above is handled like R5.
- R8: A tag-1 request raises ext_req_valid in the next cycle, carrying the index, the write flag and the write data. These are held until ext_req_ready is seen high.
- R9: While an external access is outstanding, req_ready is 0 and no other request is taken. One cycle after ext_rsp_valid, rsp_valid=1 with rsp_err=0, and rsp_rdata holds the external data for a load or 0 for a store. req_ready is 1 again in that same cycle.
- R10: Outside an external access, req_ready is 1, and on-chip requests can be accepted on every consecutive cycle.
- R11: In reset, and in the first cycle after reset, req_ready=1, rsp_valid=0 and ext_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Tag (31:23) and index (22:0) |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Response for the request accepted earlier |
| rsp_err | output | 1 | Null, unassigned tag or out-of-range index |
| rsp_rdata | output | 32 | Load data, zero-extended; 0 for stores and errors |
| ext_req_valid | output | 1 | External request present |
| ext_req_write | output | 1 | External request is a store |
| ext_req_addr | output | 23 | Index forwarded to external memory |
| ext_req_wdata | output | 32 | External store data |
| ext_req_ready | input | 1 | External side takes the request |
| ext_rsp_valid | input | 1 | External response present |
| ext_rsp_rdata | input | 32 | External load data |

## Verification
Two functions can land in the same cycle: the return of a load's data, and the acceptance of the next request. That next request may be a store to the very entry just read, or an access to a different array. The bench issues random requests back to back, including a load and then a store to the same entry. It checks that each returned word comes from the array named by the earlier tag and shows the value held before the store. A second overlap comes from requests that arrive during an external stall. The bench drives such a store during the stall and later loads the entry, expecting the old contents.

// File: rtl/tagmem_pkg.sv
// Shared constants and types for the tag-decoded memory controller.
// Assumes tag values 0 and 1 are reserved and arrays start at tag 2.
package tagmem_pkg;
    localparam int unsigned TAG_NULL = 0;
    localparam int unsigned TAG_EXT  = 1;
    localparam int unsigned TAG_BASE = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EXT_REQ  = 2'd1,
        ST_EXT_WAIT = 2'd2
    } ext_state_e;
endpackage

// File: rtl/tagmem_decode.sv
// Tag/index decoder: one-hot array select, external flag and error flag.
// Assumes NUM_ARR arrays own tags TAG_BASE..TAG_BASE+NUM_ARR-1; every other
// tag except TAG_EXT, and any index at or past an array's depth, is an error.
module tagmem_decode
    import tagmem_pkg::*;
#(
    parameter int unsigned TAG_W   = 9,
    parameter int unsigned IDX_W   = 23,
    parameter int unsigned NUM_ARR = 2,
    parameter int unsigned ARR_DEPTH [NUM_ARR] = '{default: 2}
) (
    input  logic [TAG_W-1:0]   tag,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_ARR-1:0] sel,
    output logic               is_ext,
    output logic               is_err
);

    // Compare the tag against every array and range-check the index.
    always_comb begin
        sel    = '0;
        is_ext = (tag == TAG_W'(TAG_EXT));
        is_err = !is_ext;
        for (int i = 0; i < NUM_ARR; i++) begin
            if (tag == TAG_W'(TAG_BASE + i) && idx < IDX_W'(ARR_DEPTH[i])) begin
                sel[i] = 1'b1;
                is_err = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tagmem_bank.sv
// One single-port block RAM holding one array, with a registered read port.
// Assumes the caller only enables it with an in-range address; the array
// contents are not reset, and the read register changes only on loads.
module tagmem_bank #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    // Write on enabled stores; capture read data on enabled loads.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rd_q      <= mem[addr];
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/tagmem_ctrl.sv
// Shared memory controller: steers tagged pointer accesses to per-array
// RAMs, rejects null/unassigned/out-of-range accesses and forwards tag-1
// accesses to external memory, stalling until the external response.
// Assumes the requester keeps req_valid stable until req_ready is high.
module tagmem_ctrl
    import tagmem_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TAG_W   = 9,
    parameter int unsigned NUM_ARR = 2,
    parameter int unsigned ARR_DEPTH [NUM_ARR] = '{100, 64},
    parameter int unsigned ARR_WIDTH [NUM_ARR] = '{32, 16},
    localparam int unsigned IDX_W  = ADDR_W - TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ext_req_valid,
    output logic              ext_req_write,
    output logic [IDX_W-1:0]  ext_req_addr,
    output logic [DATA_W-1:0] ext_req_wdata,
    input  logic              ext_req_ready,
    input  logic              ext_rsp_valid,
    input  logic [DATA_W-1:0] ext_rsp_rdata
);

    logic [TAG_W-1:0]   tag;
    logic [IDX_W-1:0]   idx;
    logic [NUM_ARR-1:0] sel;
    logic               is_ext;
    logic               is_err;
    logic               accept;

    ext_state_e         state_q;
    logic               ext_wr_q;
    logic [IDX_W-1:0]   ext_addr_q;
    logic [DATA_W-1:0]  ext_wdata_q;

    logic               rsp_valid_q;
    logic               rsp_err_q;
    logic               rsp_ext_q;
    logic [NUM_ARR-1:0] rsp_sel_q;
    logic [DATA_W-1:0]  ext_data_q;
    logic [DATA_W-1:0]  bank_rd [NUM_ARR];

    assign tag       = req_addr[ADDR_W-1 -: TAG_W];
    assign idx       = req_addr[IDX_W-1:0];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    tagmem_decode #(
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W),
        .NUM_ARR  (NUM_ARR),
        .ARR_DEPTH(ARR_DEPTH)
    ) u_decode (
        .tag   (tag),
        .idx   (idx),
        .sel   (sel),
        .is_ext(is_ext),
        .is_err(is_err)
    );

    for (genvar g = 0; g < NUM_ARR; g++) begin : g_bank
        localparam int unsigned BW  = ARR_WIDTH[g];
        localparam int unsigned BAW = (ARR_DEPTH[g] > 1) ? $clog2(ARR_DEPTH[g]) : 1;
        logic [BW-1:0] rd;

        tagmem_bank #(
            .DEPTH(ARR_DEPTH[g]),
            .WIDTH(BW)
        ) u_bank (
            .clk  (clk),
            .en   (accept && sel[g]),
            .we   (req_write),
            .addr (idx[BAW-1:0]),
            .wdata(req_wdata[BW-1:0]),
            .rdata(rd)
        );

        // Zero-extend the element onto the shared data width.
        assign bank_rd[g] = DATA_W'(rd);
    end

    // External access sequencer: hold the request, then wait for the answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ext_wr_q    <= 1'b0;
            ext_addr_q  <= '0;
            ext_wdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept && is_ext) begin
                    state_q     <= ST_EXT_REQ;
                    ext_wr_q    <= req_write;
                    ext_addr_q  <= idx;
                    ext_wdata_q <= req_wdata;
                end
                ST_EXT_REQ:  if (ext_req_ready) state_q <= ST_EXT_WAIT;
                ST_EXT_WAIT: if (ext_rsp_valid) state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    // Response register: records which source answers in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_ext_q   <= 1'b0;
            rsp_sel_q   <= '0;
            ext_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_ext_q   <= 1'b0;
            rsp_sel_q   <= '0;
            if (accept && !is_ext) begin
                rsp_valid_q <= 1'b1;
                rsp_err_q   <= is_err;
                rsp_sel_q   <= req_write ? '0 : sel;
            end
            if (state_q == ST_EXT_WAIT && ext_rsp_valid) begin
                rsp_valid_q <= 1'b1;
                rsp_ext_q   <= 1'b1;
                ext_data_q  <= ext_wr_q ? '0 : ext_rsp_rdata;
            end
        end
    end

    // Return mux: OR of the sources enabled by the registered select.
    always_comb begin
        rsp_rdata = rsp_ext_q ? ext_data_q : '0;
        for (int i = 0; i < NUM_ARR; i++) begin
            if (rsp_sel_q[i]) rsp_rdata = rsp_rdata | bank_rd[i];
        end
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_err       = rsp_err_q;
    assign ext_req_valid = (state_q == ST_EXT_REQ);
    assign ext_req_write = ext_wr_q;
    assign ext_req_addr  = ext_addr_q;
    assign ext_req_wdata = ext_wdata_q;

endmodule

// File: rtl/tagmem_chk.sv
// Protocol checker for tagmem_ctrl, attached through bind; observes ports only.
module tagmem_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 9,
    localparam int unsigned IDX_W = ADDR_W - TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              ext_req_valid,
    input logic [IDX_W-1:0]  ext_req_addr,
    input logic              ext_req_ready
);
    localparam logic [TAG_W-1:0] EXT_TAG = TAG_W'(1);

    // R2: every on-chip or rejected request is answered in the next cycle.
    p_onchip_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_addr[ADDR_W-1 -: TAG_W] != EXT_TAG |=> rsp_valid);

    // R5: an error response never carries data.
    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == '0);

    // R8: a tag-1 request appears on the external port with its index.
    p_ext_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_addr[ADDR_W-1 -: TAG_W] == EXT_TAG
        |=> ext_req_valid && ext_req_addr == $past(req_addr[IDX_W-1:0]));

    // R8: the external request is held until taken.
    p_ext_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_valid && !ext_req_ready |=> ext_req_valid && $stable(ext_req_addr));

    // R9: no request is taken while the external request is pending.
    p_ext_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_valid |-> !req_ready);
endmodule

bind tagmem_ctrl tagmem_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .ext_req_valid(ext_req_valid),
    .ext_req_addr (ext_req_addr),
    .ext_req_ready(ext_req_ready)
);

// File: tb/tagmem_ctrl_tb.sv
// Self-checking bench: random mixed traffic plus directed corner cases.
module tagmem_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        ext_req_valid, ext_req_write;
    logic [22:0] ext_req_addr;
    logic [31:0] ext_req_wdata;
    logic        ext_req_ready, ext_rsp_valid;
    logic [31:0] ext_rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] mdl [2][128];
    bit          pend = 1'b0;
    bit          pend_err;
    logic [31:0] pend_data;
    string       pend_req;

    always #10 clk = ~clk;

    tagmem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_req_valid(ext_req_valid), .ext_req_write(ext_req_write),
        .ext_req_addr(ext_req_addr), .ext_req_wdata(ext_req_wdata),
        .ext_req_ready(ext_req_ready), .ext_rsp_valid(ext_rsp_valid),
        .ext_rsp_rdata(ext_rsp_rdata)
    );

    function automatic int depth_of(int a);
        return (a == 0) ? 100 : 64;
    endfunction

    function automatic logic [31:0] mask_of(int a);
        return (a == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            chk(rsp_valid == 1'b1, pend_req, {31'd0, rsp_valid}, 32'd1);
            chk(rsp_err == pend_err, pend_req, {31'd0, rsp_err}, {31'd0, pend_err});
            chk(rsp_rdata == pend_data, pend_req, rsp_rdata, pend_data);
        end else begin
            chk(rsp_valid == 1'b0, "R10", {31'd0, rsp_valid}, 32'd0);
        end
        pend = 1'b0;
    endtask

    // One on-chip or rejected request; checks the previous one's response.
    task automatic onchip(bit we, int tag, int idx, logic [31:0] wd);
        int  a;
        bit  ok;
        check_pending();
        chk(req_ready == 1'b1, "R10", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = {tag[8:0], idx[22:0]};
        req_wdata = wd;
        a  = tag - 2;
        ok = (tag >= 2) && (tag < 4) && (idx < depth_of(a));
        pend      = 1'b1;
        pend_err  = !ok;
        pend_data = 32'd0;
        if (tag == 0)              pend_req = "R5";
        else if (tag >= 4)         pend_req = "R7";
        else if (!ok)              pend_req = "R6";
        else if (we)               pend_req = "R3";
        else if (a == 1)           pend_req = "R4";
        else                       pend_req = "R2";
        if (ok && we)  mdl[a][idx] = wd & mask_of(a);
        if (ok && !we) pend_data   = mdl[a][idx];
        @(negedge clk);
    endtask

    task automatic idle();
        check_pending();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // One external access with optional stall and an intruding request.
    task automatic ext_op(bit we, int idx, logic [31:0] wd, logic [31:0] rd,
                          int rdy_dly, int rsp_dly, bit intrude);
        idle();
        req_valid = 1'b1;
        req_write = we;
        req_addr  = {9'd1, idx[22:0]};
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ext_req_valid == 1'b1, "R8", {31'd0, ext_req_valid}, 32'd1);
        chk(ext_req_addr == idx[22:0], "R8", {9'd0, ext_req_addr}, {9'd0, idx[22:0]});
        chk(ext_req_write == we, "R8", {31'd0, ext_req_write}, {31'd0, we});
        chk(ext_req_wdata == wd, "R8", ext_req_wdata, wd);
        chk(req_ready == 1'b0, "R9", {31'd0, req_ready}, 32'd0);
        if (intrude) begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = {9'd2, 23'd5};
            req_wdata = 32'hDEAD_BEEF;
        end
        for (int k = 0; k < rdy_dly; k++) begin
            @(negedge clk);
            chk(ext_req_valid == 1'b1, "R8", {31'd0, ext_req_valid}, 32'd1);
            chk(rsp_valid == 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
        end
        ext_req_ready = 1'b1;
        @(negedge clk);
        ext_req_ready = 1'b0;
        chk(ext_req_valid == 1'b0, "R8", {31'd0, ext_req_valid}, 32'd0);
        chk(req_ready == 1'b0, "R9", {31'd0, req_ready}, 32'd0);
        for (int k = 0; k < rsp_dly; k++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
            chk(req_ready == 1'b0, "R9", {31'd0, req_ready}, 32'd0);
        end
        req_valid     = 1'b0;
        ext_rsp_valid = 1'b1;
        ext_rsp_rdata = rd;
        @(negedge clk);
        ext_rsp_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R9", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_err == 1'b0, "R9", {31'd0, rsp_err}, 32'd0);
        chk(rsp_rdata == (we ? 32'd0 : rd), "R9", rsp_rdata, we ? 32'd0 : rd);
        chk(req_ready == 1'b1, "R9", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy    = $urandom(32'h5EED_0042);
        rst_n         = 1'b0;
        req_valid     = 1'b0;
        req_write     = 1'b0;
        req_addr      = '0;
        req_wdata     = '0;
        ext_req_ready = 1'b0;
        ext_rsp_valid = 1'b0;
        ext_rsp_rdata = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R11", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R11", {31'd0, rsp_valid}, 32'd0);
        chk(ext_req_valid == 1'b0, "R11", {31'd0, ext_req_valid}, 32'd0);

        // Fill both arrays back to back (R3, R10).
        for (int a = 0; a < 2; a++)
            for (int i = 0; i < depth_of(a); i++)
                onchip(1'b1, a + 2, i, $urandom);

        // Directed corners.
        onchip(1'b0, 2, 13, 0);                 // R1 element 13 of array 0
        onchip(1'b0, 2, 99, 0);                 // R2 last entry
        onchip(1'b0, 2, 100, 0);                // R6 one past end
        onchip(1'b0, 3, 63, 0);                 // R4 last entry
        onchip(1'b1, 3, 64, 32'h0000_5A5A);     // R6 would alias entry 0
        onchip(1'b0, 3, 0, 0);                  // R6 entry 0 unchanged
        onchip(1'b1, 0, 7, 32'h1111_1111);      // R5 null store
        onchip(1'b0, 0, 7, 0);                  // R5 null load
        onchip(1'b0, 4, 1, 0);                  // R7
        onchip(1'b1, 511, 1, 32'h2222_2222);    // R7
        onchip(1'b1, 3, 7, 32'hFFFF_ABCD);      // R4 store wide value
        onchip(1'b0, 3, 7, 0);                  // R4 expect 0000ABCD
        onchip(1'b0, 2, 20, 0);                 // R10 load then store same entry
        onchip(1'b1, 2, 20, 32'h0BAD_F00D);
        onchip(1'b0, 2, 20, 0);
        ext_op(1'b0, 23'h12345, 32'd0, 32'hCAFE_F00D, 2, 3, 1'b1);
        ext_op(1'b1, 23'h7FFFFF, 32'h1234_5678, 32'hFFFF_FFFF, 0, 0, 1'b0);
        onchip(1'b0, 2, 5, 0);                  // R9 intruding store dropped

        // Random traffic.
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            int tag, idx;
            r = $urandom % 64;
            if (r == 0) begin
                ext_op(($urandom % 2) == 1, $urandom % (1 << 23), $urandom, $urandom,
                       $urandom % 3, $urandom % 4, ($urandom % 2) == 1);
            end else begin
                r = $urandom % 16;
                if (r < 6)       begin tag = 2; idx = $urandom % 100; end
                else if (r < 12) begin tag = 3; idx = $urandom % 64; end
                else if (r == 12) begin tag = 0; idx = $urandom % 128; end
                else if (r == 13) begin tag = 4 + ($urandom % 508); idx = $urandom % 64; end
                else if (r == 14) begin tag = 2; idx = 100 + ($urandom % 30); end
                else             begin tag = 3; idx = 64 + ($urandom % 70); end
                onchip(($urandom % 2) == 1, tag, idx, $urandom);
            end
        end
        idle();
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule